// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal single-beat request bus and an external asynchronous static RAM of 512K bytes. The RAM has active-low select, output-enable and write-enable strobes. A requester offers a read or a write with a valid/ready handshake. The controller turns that request into a sequence of registered strobe levels on the RAM pins. It holds each phase for a parameterised number of clock cycles, so the RAM's minimum access time, write-pulse width and data setup are met at the chosen clock period.

Each cycle count is the ceiling of the RAM timing divided by the clock period, with a minimum of one. Reads return the sampled byte with a one-cycle valid pulse. Writes always end on the rising edge of write enable. Select stays low across the whole write.

The shared data bus is split into out, drive-enable and in signals. The controller drives the bus only during a write's setup and pulse phases. Before any write that follows a read, it waits for the RAM's output drivers to turn off.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `ram_cs_n`, `ram_oe_n` and `ram_we_n` are 1, `ram_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only while the controller is idle. In the cycle after a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge), `req_ready` is 0, and it stays 0 until the strobes have returned high.
- R3: An accepted read (`req_write` = 0) drives the following for exactly READ_CYCLES cycles, starting in the cycle after acceptance:
  - `ram_cs_n` = 0, `ram_oe_n` = 0 and `ram_we_n` = 1;
  - `ram_dq_oe` = 0;
  - `ram_addr` equal to the request address.
- R4: `rsp_valid` is 1 for exactly one cycle, the first cycle after the read strobes rise. In that cycle `rsp_rdata` equals the byte that was on `ram_dq_in` in the last cycle of the read strobe.
- R5: An accepted write (`req_write` = 1) first spends DATA_SETUP_CYCLES cycles in a setup phase:
  - `ram_cs_n` = 0, `ram_we_n` = 1 and `ram_oe_n` = 1;
  - `ram_dq_oe` = 1;
  - `ram_dq_out` equal to the write byte and `ram_addr` equal to the request address.
- R6: The setup phase is followed by exactly WE_PULSE_CYCLES cycles with `ram_we_n` = 0, `ram_cs_n` = 0, `ram_oe_n` = 1 and the bus still driven. At the clock edge that ends the pulse, `ram_we_n` and `ram_cs_n` return to 1 and `ram_dq_oe` returns to 0 together.
- R7: `ram_dq_oe` is 1 only while `ram_cs_n` = 0 and `ram_oe_n` = 1. `ram_we_n` is 0 only while `ram_dq_oe` = 1.
- R8: If a read has been accepted since the last write, an accepted write first spends exactly TURNAROUND_CYCLES cycles with all three strobes at 1 and `ram_dq_oe` = 0. Otherwise the setup phase begins in the cycle after acceptance.
- R9: `ram_addr` stays constant for every cycle that `ram_cs_n` stays 0. `ram_dq_out` stays constant for every cycle that `ram_dq_oe` stays 1.
- R10: While no request is offered, all strobes stay at 1 and `ram_dq_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | DATA_W | Byte returned by a read |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_out | output | DATA_W | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for the data pins |
| ram_dq_in | input | DATA_W | Data received from the RAM pins |

## Verification
The embedded properties watch every cycle for the following:
- bus-drive safety against the strobe levels;
- the lengths of the read strobe, the setup phase and the write pulse, measured with run counters;
- the minimum quiet gap with output enable high before the bus is driven;
- a stable address and stable write data while selected;
- the single-cycle response pulse and the handshake dropping after acceptance.

Only the bench scenarios show the following:
- the exact number of turnaround cycles, which depends on whether a read came before the write;
- that written bytes land at the right addresses and come back intact across a full address sweep;
- that back-to-back reads and writes take no extra gap.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  function automatic strobe_t strobes_for(state_e s);
    strobe_t r;
    r = STROBE_IDLE;
    case (s)
      ST_READ: begin
        r.cs_n = 1'b0;
        r.oe_n = 1'b0;
      end
      ST_WSETUP: begin
        r.cs_n  = 1'b0;
        r.dq_oe = 1'b1;
      end
      ST_WPULSE: begin
        r.cs_n  = 1'b0;
        r.we_n  = 1'b0;
        r.dq_oe = 1'b1;
      end
      default: r = STROBE_IDLE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= load_val;
    end else if (count_q != '0) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign done = (count_q == '0);
endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) dout <= din;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W            = 19,
  parameter int DATA_W            = 8,
  parameter int READ_CYCLES       = 5,
  parameter int WE_PULSE_CYCLES   = 4,
  parameter int DATA_SETUP_CYCLES = 1,
  parameter int TURNAROUND_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int MAX_A  = (READ_CYCLES > WE_PULSE_CYCLES) ? READ_CYCLES : WE_PULSE_CYCLES;
  localparam int MAX_B  = (DATA_SETUP_CYCLES > TURNAROUND_CYCLES) ? DATA_SETUP_CYCLES : TURNAROUND_CYCLES;
  localparam int MAXC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAXC + 2) + 1;
  localparam logic [CNT_W-1:0] LD_READ  = CNT_W'(READ_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(WE_PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(DATA_SETUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURNAROUND_CYCLES - 1);

  state_e            state_q, state_d;
  strobe_t           strb_q;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              accept, capture;
  logic              read_since_write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_READ) && tmr_done;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (!req_write) begin
            state_d = ST_READ;
            tmr_val = LD_READ;
          end else if (read_since_write_q) begin
            state_d = ST_TURN;
            tmr_val = LD_TURN;
          end else begin
            state_d = ST_WSETUP;
            tmr_val = LD_SETUP;
          end
        end
      end
      ST_TURN: if (tmr_done) begin
        state_d  = ST_WSETUP;
        tmr_load = 1'b1;
        tmr_val  = LD_SETUP;
      end
      ST_READ: if (tmr_done) state_d = ST_IDLE;
      ST_WSETUP: if (tmr_done) begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = LD_PULSE;
      end
      ST_WPULSE: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q            <= ST_IDLE;
      strb_q             <= STROBE_IDLE;
      addr_q             <= '0;
      wdata_q            <= '0;
      read_since_write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      strb_q  <= strobes_for(state_d);
      if (accept) begin
        addr_q             <= req_addr;
        wdata_q            <= req_wdata;
        read_since_write_q <= !req_write;
      end
    end
  end

  asram_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  asram_rdcap #(.W(DATA_W)) u_rdcap (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .din     (ram_dq_in),
    .dout    (rsp_rdata),
    .valid   (rsp_valid)
  );

  assign ram_addr   = addr_q;
  assign ram_dq_out = wdata_q;
  assign ram_cs_n   = strb_q.cs_n;
  assign ram_oe_n   = strb_q.oe_n;
  assign ram_we_n   = strb_q.we_n;
  assign ram_dq_oe  = strb_q.dq_oe;

  // Run counters that measure strobe phases at the pins for the properties below
  localparam int RUN_W = CNT_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  logic [RUN_W-1:0] rd_run, we_run, su_run, quiet_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_run    <= '0;
      we_run    <= '0;
      su_run    <= '0;
      quiet_run <= RUN_MAX;
    end else begin
      rd_run    <= !ram_oe_n ? ((rd_run == RUN_MAX) ? rd_run : rd_run + 1'b1) : '0;
      we_run    <= !ram_we_n ? ((we_run == RUN_MAX) ? we_run : we_run + 1'b1) : '0;
      su_run    <= (ram_dq_oe && ram_we_n) ? ((su_run == RUN_MAX) ? su_run : su_run + 1'b1) : '0;
      quiet_run <= !ram_oe_n ? '0 : ((quiet_run == RUN_MAX) ? quiet_run : quiet_run + 1'b1);
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_ready_only_strobes_high_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n));
  p_read_strobe_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_oe_n) |-> (rd_run == RUN_W'(READ_CYCLES)));
  p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(ram_oe_n));
  p_rsp_single_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  p_setup_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> (su_run == RUN_W'(DATA_SETUP_CYCLES)));
  p_pulse_len_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (we_run == RUN_W'(WE_PULSE_CYCLES)));
  p_pulse_end_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> (ram_cs_n && !ram_dq_oe));
  p_drive_safe_r7: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (!ram_cs_n && ram_oe_n));
  p_we_needs_drive_r7: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> ram_dq_oe);
  p_turn_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_dq_oe) |-> (quiet_run > RUN_W'(TURNAROUND_CYCLES)));
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!ram_cs_n && !$past(ram_cs_n)) |-> $stable(ram_addr));
  p_wdata_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out));
endmodule

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int RDC = 3;
  localparam int WEC = 2;
  localparam int SUC = 2;
  localparam int TAC = 2;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] ram_addr;
  logic ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [DW-1:0] ram_dq_out, ram_dq_in;

  logic [DW-1:0] ram_model [NADDR];
  logic [DW-1:0] exp_mem   [NADDR];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .READ_CYCLES(RDC), .WE_PULSE_CYCLES(WEC),
    .DATA_SETUP_CYCLES(SUC), .TURNAROUND_CYCLES(TAC)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // RAM model: drives data while selected and output-enabled, stores while write-enabled
  assign ram_dq_in = (!ram_cs_n && !ram_oe_n) ? ram_model[ram_addr] : 8'h5A;
  always @(negedge clk) begin
    if (!ram_cs_n && !ram_we_n && ram_dq_oe) ram_model[ram_addr] <= ram_dq_out;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Called just after a falling edge with the controller idle
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int exp_turn);
    int t = 0, s = 0, p = 0, guard = 0;
    bit done = 0, bad_turn = 0, bad_drive = 0, bad_pulse = 0, bad_rdy = 0;
    chk(req_ready == 1'b1, "R2 ready before write", int'(req_ready), 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!done && guard < 100) begin
      @(negedge clk); guard++;
      if (!ram_we_n) begin
        p++;
        if (ram_cs_n || !ram_oe_n || !ram_dq_oe || ram_addr != a || ram_dq_out != d) bad_pulse = 1;
      end else if (ram_dq_oe) begin
        s++;
        if (ram_cs_n || !ram_oe_n || p != 0 || ram_addr != a || ram_dq_out != d) bad_drive = 1;
      end else if (p > 0) begin
        done = 1;
      end else begin
        t++;
        if (!ram_cs_n || !ram_oe_n || s != 0) bad_turn = 1;
      end
      if (!done && req_ready) bad_rdy = 1;
    end
    chk(done, "R6 write finished", int'(done), 1);
    chk(t == exp_turn, "R8 turnaround cycles", t, exp_turn);
    chk(!bad_turn, "R8 turnaround strobes high", int'(bad_turn), 0);
    chk(s == SUC, "R5 setup cycles", s, SUC);
    chk(!bad_drive, "R5 setup levels addr data", int'(bad_drive), 0);
    chk(p == WEC, "R6 pulse cycles", p, WEC);
    chk(!bad_pulse, "R7 R9 pulse levels addr data", int'(bad_pulse), 0);
    chk(!bad_rdy, "R2 ready low while busy", int'(bad_rdy), 0);
    chk(ram_cs_n && ram_we_n && !ram_dq_oe, "R6 release at pulse end",
        {ram_cs_n, ram_we_n, ram_dq_oe}, 3'b110);
    exp_mem[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int n = 0, guard = 0;
    bit got = 0, bad = 0, bad_rdy = 0;
    logic [DW-1:0] v = '0;
    chk(req_ready == 1'b1, "R2 ready before read", int'(req_ready), 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!got && guard < 100) begin
      @(negedge clk); guard++;
      if (rsp_valid) begin
        got = 1; v = rsp_rdata;
        if (!ram_cs_n || !ram_oe_n) bad = 1;
      end else begin
        if (!ram_cs_n) begin
          n++;
          if (ram_oe_n || !ram_we_n || ram_dq_oe || ram_addr != a) bad = 1;
        end
        if (req_ready) bad_rdy = 1;
      end
    end
    chk(got, "R4 response seen", int'(got), 1);
    chk(n == RDC, "R3 read strobe cycles", n, RDC);
    chk(!bad, "R3 R7 read levels and address", int'(bad), 0);
    chk(!bad_rdy, "R2 ready low during read", int'(bad_rdy), 0);
    chk(v == exp_mem[a], "R4 read data", int'(v), int'(exp_mem[a]));
    @(negedge clk);
    chk(!rsp_valid, "R4 valid single cycle", int'(rsp_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < NADDR; i++) begin
      ram_model[i] = '0;
      exp_mem[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(ram_cs_n && ram_oe_n && ram_we_n, "R1 strobes high", {ram_cs_n, ram_oe_n, ram_we_n}, 7);
    chk(!ram_dq_oe, "R1 bus released", int'(ram_dq_oe), 0);
    chk(req_ready && !rsp_valid, "R1 ready and no response", {req_ready, rsp_valid}, 2);

    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(ram_cs_n && ram_oe_n && ram_we_n && !ram_dq_oe, "R10 idle strobes",
          {ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe}, 14);
    end

    // Writes with no prior read: no turnaround
    for (int a = 0; a < NADDR; a++)
      do_write(AW'(a), DW'(a * 29 + 7), 0);
    // Back-to-back reads of every address
    for (int a = 0; a < NADDR; a++)
      do_read(AW'(a));
    // Alternating write/read: every write follows a read
    for (int a = NADDR - 1; a >= 0; a--) begin
      do_write(AW'(a), DW'(a * 53 + 200), TAC);
      do_read(AW'(a));
    end
    // Read, idle gap, then write still waits for turnaround
    do_read(AW'(5));
    repeat (4) @(negedge clk);
    do_write(AW'(9), 8'hC3, TAC);
    do_write(AW'(10), 8'h3C, 0);
    do_read(AW'(9));
    do_read(AW'(10));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule